// File: doc/BRIEF.md
# L2 MAC Hash Bucket Indexer

This block turns a layer-2 lookup key into addresses inside the hashed part of a forwarding table. The key is a 48-bit station MAC address together with a 12-bit VLAN ID. The two are joined into a 60-bit seed, with the VLAN ID in bits 59:48 and the MAC in bits 47:0. A per-request select bit picks one of two fold functions that reduce the seed to a 12-bit bucket hash.

Each bucket holds four entries. A lookup engine sends one request with a single-cycle strobe. The block answers one cycle later and then spends four consecutive cycles presenting the table address of each entry in the bucket, in position order. This lets the engine probe the bucket one entry at a time. The emitted address is the hash in bits 13:2 and the position in bits 1:0. The bank-select bit above it is always zero, which selects the hash memory, so it is not driven.

Top module: `l2h_bucket_indexer`

## Requirements
- R1: After reset, out_valid is 0 and out_pos, out_hash and out_addr are all zero.
- R2: With in_mode = 0 (chunk fold), the hash is the XOR of five 12-bit values: mac[11:0], mac[23:12], mac[35:24], mac[47:36], and the VLAN ID with its halves exchanged, {vid[5:0], vid[11:6]}.
- R3: With in_mode = 1 (slice fold), hash[11:6] is the XOR of seed slices [59:54], [41:36], [35:30], [17:12] and [11:6]. hash[5:0] is the XOR of seed slices [53:48], [47:42], [29:24], [23:18] and [5:0].
- R4: A strobe that is accepted at a clock edge gives out_valid = 1 with out_pos = 0 after that same edge, which is one cycle of latency.
- R5: An accepted request produces exactly four valid beats on consecutive cycles, with out_pos going 0, 1, 2, 3. out_valid then drops unless a new request is accepted.
- R6: While out_valid is 1, out_addr equals {out_hash, out_pos}: the hash sits in bits 13:2 and the position in bits 1:0.
- R7: During a burst, out_hash stays constant even when in_mac, in_vid or in_mode change.
- R8: A strobe that arrives while beat 0, 1 or 2 is showing is ignored. The running burst continues with its own hash, and no extra burst follows.
- R9: A strobe that arrives while beat 3 is showing is accepted. The next cycle shows beat 0 of the new request with no idle cycle between the two bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_mac | input | 48 | MAC address of the key |
| in_vid | input | 12 | VLAN ID of the key |
| in_mode | input | 1 | Fold select: 0 = chunk fold, 1 = slice fold |
| out_valid | output | 1 | A bucket address beat is present |
| out_hash | output | 12 | Bucket hash of the current request |
| out_pos | output | 2 | Entry position within the bucket |
| out_addr | output | 14 | Hash-memory address of the entry |

## Verification
The bench aims at the fold corners. It uses all-ones MAC addresses whose chunks cancel, and a key that has only VLAN bits set. That key separates the exchanged VLAN halves in the chunk fold from the split slices in the slice fold. A design that misses the half swap, or that puts a slice in the wrong half, returns a different hash for these keys.

On the sequencing side, the bench sends strobes in the middle of a burst and on its final beat, and it changes the key inputs while a burst is running. A design that restarts early, adds a gap between bursts, or lets the live inputs through shows a wrong position, a wrong hash or an extra valid beat.

// File: rtl/l2h_pkg.sv
package l2h_pkg;
  localparam int MAC_W  = 48;
  localparam int VID_W  = 12;
  localparam int HASH_W = 12;
  localparam int WAYS   = 4;

  typedef enum logic {
    FOLD_CHUNK = 1'b0,
    FOLD_SLICE = 1'b1
  } fold_mode_e;
endpackage

// File: rtl/l2h_fold.sv
module l2h_fold
  import l2h_pkg::*;
#(
  parameter int MAC_BITS  = MAC_W,
  parameter int VID_BITS  = VID_W,
  parameter int HASH_BITS = HASH_W
) (
  input  logic [MAC_BITS-1:0]  mac,
  input  logic [VID_BITS-1:0]  vid,
  input  fold_mode_e           mode,
  output logic [HASH_BITS-1:0] hash
);
  localparam int SEED_W  = MAC_BITS + VID_BITS;
  localparam int HALF    = HASH_BITS / 2;
  localparam int GRP_W   = 2 * HASH_BITS;
  localparam int N_GRP   = (SEED_W + GRP_W - 1) / GRP_W;
  localparam int EXT_W   = N_GRP * GRP_W;
  localparam int N_CHUNK = MAC_BITS / HASH_BITS;

  logic [EXT_W-1:0]     seed_ext;
  logic [HALF-1:0]      lo_part [N_GRP];
  logic [HALF-1:0]      hi_part [N_GRP];
  logic [HASH_BITS-1:0] chunk   [N_CHUNK];
  logic [HASH_BITS-1:0] vid_swap;
  logic [HALF-1:0]      acc_lo, acc_hi;
  logic [HASH_BITS-1:0] acc_ck;

  assign seed_ext = {{(EXT_W-SEED_W){1'b0}}, vid, mac};
  assign vid_swap = {vid[HALF-1:0], vid[VID_BITS-1:HALF]};

  // Each 24-bit group gives its outer slices to the low half of the hash
  // and its inner slices to the high half.
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign lo_part[g] = seed_ext[g*GRP_W +: HALF] ^ seed_ext[g*GRP_W + 3*HALF +: HALF];
    assign hi_part[g] = seed_ext[g*GRP_W + HALF +: HALF] ^ seed_ext[g*GRP_W + 2*HALF +: HALF];
  end

  for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
    assign chunk[c] = mac[c*HASH_BITS +: HASH_BITS];
  end

  always_comb begin
    acc_lo = '0;
    acc_hi = '0;
    for (int g = 0; g < N_GRP; g++) begin
      acc_lo = acc_lo ^ lo_part[g];
      acc_hi = acc_hi ^ hi_part[g];
    end
    acc_ck = vid_swap;
    for (int c = 0; c < N_CHUNK; c++) begin
      acc_ck = acc_ck ^ chunk[c];
    end
    hash = (mode == FOLD_SLICE) ? {acc_hi, acc_lo} : acc_ck;
  end
endmodule

// File: rtl/l2h_probe_seq.sv
module l2h_probe_seq
  import l2h_pkg::*;
#(
  parameter int N_WAYS = WAYS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req,
  output logic                      accept,
  output logic                      vld,
  output logic [$clog2(N_WAYS)-1:0] pos,
  output logic                      last
);
  localparam int POS_W = $clog2(N_WAYS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_WAYS - 1);

  logic             vld_d;
  logic [POS_W-1:0] pos_d;

  assign last   = vld && (pos == LAST_POS);
  assign accept = req && (!vld || last);

  always_comb begin
    vld_d = vld;
    pos_d = pos;
    if (accept) begin
      vld_d = 1'b1;
      pos_d = '0;
    end else if (vld) begin
      if (last) begin
        vld_d = 1'b0;
        pos_d = '0;
      end else begin
        pos_d = pos + POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      pos <= '0;
    end else begin
      vld <= vld_d;
      pos <= pos_d;
    end
  end

  assert_first_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (vld && pos == '0));
  assert_next_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !last) |=> (vld && pos == $past(pos) + POS_W'(1)));
  assert_burst_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !req) |=> !vld);
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !last && req) |=> (pos != '0));
endmodule

// File: rtl/l2h_bucket_indexer.sv
module l2h_bucket_indexer
  import l2h_pkg::*;
#(
  parameter int MAC_BITS  = MAC_W,
  parameter int VID_BITS  = VID_W,
  parameter int HASH_BITS = HASH_W,
  parameter int N_WAYS    = WAYS,
  localparam int POS_W    = $clog2(N_WAYS),
  localparam int ADDR_W   = HASH_BITS + POS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [MAC_BITS-1:0]  in_mac,
  input  logic [VID_BITS-1:0]  in_vid,
  input  logic                 in_mode,
  output logic                 out_valid,
  output logic [HASH_BITS-1:0] out_hash,
  output logic [POS_W-1:0]     out_pos,
  output logic [ADDR_W-1:0]    out_addr
);
  logic                 accept;
  logic                 last;
  logic [HASH_BITS-1:0] fold_hash;
  logic [HASH_BITS-1:0] hash_d, hash_q;
  fold_mode_e           mode_sel;

  assign mode_sel = fold_mode_e'(in_mode);

  l2h_fold #(
    .MAC_BITS (MAC_BITS),
    .VID_BITS (VID_BITS),
    .HASH_BITS(HASH_BITS)
  ) u_fold (
    .mac (in_mac),
    .vid (in_vid),
    .mode(mode_sel),
    .hash(fold_hash)
  );

  l2h_probe_seq #(
    .N_WAYS(N_WAYS)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (in_valid),
    .accept(accept),
    .vld   (out_valid),
    .pos   (out_pos),
    .last  (last)
  );

  always_comb begin
    hash_d = hash_q;
    if (accept) hash_d = fold_hash;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hash_q <= '0;
    else        hash_q <= hash_d;
  end

  assign out_hash = hash_q;
  assign out_addr = {hash_q, out_pos};

  assert_hold_hash_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !last) |=> $stable(out_hash));
  assert_load_hash_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_hash == $past(fold_hash)));
  assert_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (last && in_valid) |=> (out_valid && out_pos == '0));
endmodule

// File: tb/l2h_bucket_indexer_tb.sv
module l2h_bucket_indexer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [47:0] in_mac;
  logic [11:0] in_vid;
  logic        in_mode;
  logic        out_valid;
  logic [11:0] out_hash;
  logic [1:0]  out_pos;
  logic [13:0] out_addr;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  l2h_bucket_indexer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mac(in_mac),
    .in_vid(in_vid), .in_mode(in_mode), .out_valid(out_valid),
    .out_hash(out_hash), .out_pos(out_pos), .out_addr(out_addr)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [11:0] ref_hash(input logic [47:0] m, input logic [11:0] v,
                                           input logic md);
    logic [5:0] hi, lo;
    if (!md)
      return {v[5:0], v[11:6]} ^ m[47:36] ^ m[35:24] ^ m[23:12] ^ m[11:0];
    hi = v[11:6] ^ m[41:36] ^ m[35:30] ^ m[17:12] ^ m[11:6];
    lo = v[5:0] ^ m[47:42] ^ m[29:24] ^ m[23:18] ^ m[5:0];
    return {hi, lo};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at the negedge where beat p is showing.
  task automatic check_beat(input string req, input logic [11:0] h, input int p);
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " pos R5"}, 32'(out_pos), 32'(p));
    check({req, " hash"}, 32'(out_hash), 32'(h));
    check({req, " addr R6"}, 32'(out_addr), 32'({h, 2'(p)}));
  endtask

  // Ends at the negedge where beat 0 is showing.
  task automatic send(input logic [47:0] m, input logic [11:0] v, input logic md);
    @(negedge clk);
    in_mac = m; in_vid = v; in_mode = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic full_burst(input string req, input logic [47:0] m, input logic [11:0] v,
                            input logic md);
    logic [11:0] h = ref_hash(m, v, md);
    send(m, v, md);
    for (int p = 0; p < 4; p++) begin
      if (p > 0) @(negedge clk);
      check_beat(req, h, p);
    end
    @(negedge clk);
    check({req, " idle after burst R5"}, 32'(out_valid), 32'd0);
  endtask

  task automatic t_reset;
    check("R1 valid", 32'(out_valid), 32'd0);
    check("R1 pos", 32'(out_pos), 32'd0);
    check("R1 hash", 32'(out_hash), 32'd0);
    check("R1 addr", 32'(out_addr), 32'd0);
  endtask

  task automatic t_chunk_fold;
    full_burst("R2 R4 zero key", 48'h0, 12'h0, 1'b0);
    full_burst("R2 ones cancel", 48'hFFFF_FFFF_FFFF, 12'h0, 1'b0);
    full_burst("R2 vid only", 48'h0, 12'hABC, 1'b0);
    full_burst("R2 mixed", 48'h0012_34AB_CDEF, 12'h5A3, 1'b0);
  endtask

  task automatic t_slice_fold;
    full_burst("R3 ones cancel", 48'hFFFF_FFFF_FFFF, 12'h0, 1'b1);
    full_burst("R3 vid only", 48'h0, 12'hABC, 1'b1);
    full_burst("R3 mixed", 48'hDEAD_BEEF_0123, 12'h7F1, 1'b1);
    full_burst("R3 single bit", 48'h0000_0000_0040, 12'h001, 1'b1);
  endtask

  task automatic t_ignore_busy;
    logic [11:0] ha = ref_hash(48'h1111_2222_3333, 12'h444, 1'b0);
    send(48'h1111_2222_3333, 12'h444, 1'b0);
    check_beat("R8 beat0", ha, 0);
    @(negedge clk);
    check_beat("R8 beat1", ha, 1);
    in_mac = 48'h9999_8888_7777; in_vid = 12'h666; in_mode = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_beat("R8 R7 beat2", ha, 2);
    @(negedge clk);
    check_beat("R8 R7 beat3", ha, 3);
    @(negedge clk);
    check("R8 no extra burst", 32'(out_valid), 32'd0);
  endtask

  task automatic t_back_to_back;
    logic [11:0] ha = ref_hash(48'hA5A5_5A5A_0F0F, 12'h321, 1'b1);
    logic [11:0] hb = ref_hash(48'h0102_0304_0506, 12'hFED, 1'b0);
    send(48'hA5A5_5A5A_0F0F, 12'h321, 1'b1);
    for (int p = 0; p < 4; p++) begin
      if (p > 0) @(negedge clk);
      check_beat("R9 first burst", ha, p);
    end
    in_mac = 48'h0102_0304_0506; in_vid = 12'hFED; in_mode = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int p = 0; p < 4; p++) begin
      if (p > 0) @(negedge clk);
      if (p == 2) begin
        in_mac = 48'hFFFF_0000_FFFF; in_vid = 12'h0; in_mode = 1'b1;
      end
      check_beat("R9 R7 second burst", hb, p);
    end
    @(negedge clk);
    check("R9 idle after chain", 32'(out_valid), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mac = '0; in_vid = '0; in_mode = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_chunk_fold;
    t_slice_fold;
    t_ignore_busy;
    t_back_to_back;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule